// File: doc/BRIEF.md
# Mains-Clocked BCD Calendar Counter

This block keeps wall-clock time and a calendar using the power line as its time base. One pulse per mains cycle, already squared by an external comparator, enters on `line_in`. A prescaler turns five or six of these pulses into one tenth of a second, depending on the selected line frequency. Ten tenths make a second. From the seconds stage the carry runs through minutes, hours, date, month, two-digit year and day of week. Every field is held in BCD.

Software loads the time fields through a byte write port. That port only accepts writes while the write-allow input is high. A write transaction ends with a stop event (`wr_done`). After reset the counter stays frozen until a time write has been accepted and its stop event has been seen. Each accepted write clears the sub-second phase, and the stop event then restarts it. A power-fail flag is high after reset and drops at the first accepted write. A snapshot strobe copies every field into a shadow register set in one cycle. Reads are served from that shadow, so a carry cannot tear a multi-byte read.

Top module: `mains_calendar`

## Requirements
- R1: After reset, the fields read through a snapshot are as follows: seconds 00, minutes 00, hour 12h (12-hour mode, AM), date 01, month 01, year 00, day of week 0 and sub-second 0. The power-fail flag reads 1 and `running` reads 0. The register addresses are: 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 day of week, 7 sub-second.
- R2: No field advances before a write has been accepted and a stop event has followed it. From that stop on, `running` is 1 and stays 1.
- R3: While `wr_allow` is 0, writes have no effect: the fields, the power-fail flag and the start condition are all untouched.
- R4: The first accepted write clears the power-fail flag. The flag is cleared in the cycle after the write and stays cleared until reset.
- R5: With `sel_50hz` = 0 (60 Hz), six line pulses make one tenth of a second. With `sel_50hz` = 1 (50 Hz), five line pulses make one tenth.
- R6: The sub-second field counts 0 to 9. It is read-only: a write to address 7 changes nothing. Any accepted write forces it to 0. The stop event re-aligns the pulse phase, so that exactly one second of pulses after the stop advances the seconds field by one.
- R7: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R8: In the hour byte, bit 7 = 1 selects 24-hour mode. In that mode the hour counts 00 to 23, and the step from 23 to 00 advances the date.
- R9: In the hour byte, bit 7 = 0 selects 12-hour mode. Bit 5 is the PM flag and bits 4:0 hold the hour as BCD 12, 01 … 11. The PM flag toggles on the step from 11 to 12. The date advances on the step from 11 PM to 12 AM.
- R10: The date wraps to 01 after day 30 in April, June, September and November, and after day 31 in the other months except February.
- R11: February has 29 days when the two-digit year is divisible by 4 and 28 days otherwise. There is no century exception.
- R12: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R13: The day of week advances with each date change and wraps from 6 to 0.
- R14: `rd_data` returns the shadow copy of the field at `rd_addr`. The shadow changes only in the cycle after `snap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| line_in | input | 1 | Squared mains pulse train, one high pulse per cycle |
| sel_50hz | input | 1 | 0: 60 Hz line, 1: 50 Hz line |
| wr_allow | input | 1 | Write-enable control for the time section |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Field address of the write |
| wr_data | input | 8 | BCD byte to write |
| wr_done | input | 1 | Stop event closing a write transaction |
| snap_req | input | 1 | Copy all live fields into the shadow |
| rd_addr | input | 3 | Field address of the read |
| rd_data | output | 8 | Shadow byte at `rd_addr` |
| running | output | 1 | Counting has been started |
| pwr_fail | output | 1 | Power-fail flag |

## Verification
The bench builds the block with its default parameters: six and five pulses per tenth, ten tenths per second, and a two-stage input synchronizer. With these values one second takes only 120 clocks. This makes several sweeps affordable. The bench steps a full minute second by second, and steps every hour of the day in both hour modes. It visits the last day of each month, and February of all hundred years. It also checks the phase counts at 50 and 60 Hz, pulse by pulse, around the tenth boundary.

// File: rtl/mcal_pkg.sv
// Shared types, field addresses and BCD helpers for the mains calendar.
// Assumes all stored field values are legal BCD within their ranges.
package mcal_pkg;

    localparam int NREG = 8;
    localparam int AW   = 3;

    localparam logic [AW-1:0] A_SEC  = 3'd0;
    localparam logic [AW-1:0] A_MIN  = 3'd1;
    localparam logic [AW-1:0] A_HOUR = 3'd2;
    localparam logic [AW-1:0] A_DATE = 3'd3;
    localparam logic [AW-1:0] A_MON  = 3'd4;
    localparam logic [AW-1:0] A_YEAR = 3'd5;
    localparam logic [AW-1:0] A_DOW  = 3'd6;
    localparam logic [AW-1:0] A_SUB  = 3'd7;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [7:0] hour;   // [7] 24h mode, [5] PM in 12h mode
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
        logic [2:0] dow;
    } mcal_time_t;

    // Increment a two-digit BCD byte (no range wrap).
    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last BCD date of a month; leap rule is the year divisible by 4 only.
    function automatic logic [5:0] month_len(input logic [4:0] mon, input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = 7'({3'b000, yr[7:4]} * 7'd10) + {3'b000, yr[3:0]};
        case (mon)
            5'h02:                      return (ybin[1:0] == 2'b00) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/mcal_tick_gen.sv
// Line-pulse prescaler: synchronizes the mains pulse, detects its rising
// edge, divides to tenths of a second and then to a one-second tick.
// Assumes line_in pulses are at least one clock high and one clock low.
module mcal_tick_gen #(
    parameter int DIV_60      = 6,
    parameter int DIV_50      = 5,
    parameter int TENTHS      = 10,
    parameter int SYNC_STAGES = 2,
    localparam int DIV_MAX    = (DIV_60 > DIV_50) ? DIV_60 : DIV_50,
    localparam int CW         = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1,
    localparam int TW         = $clog2(TENTHS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_in,
    input  logic          sel_50hz,
    input  logic          run,
    input  logic          realign,
    output logic          sec_tick,
    output logic [TW-1:0] tenths
);

    logic          line_s;
    logic          line_q;
    logic          edge_s;
    logic [CW-1:0] cyc_q;
    logic [CW-1:0] div_lim;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign line_s = line_in;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            // Purpose: metastability chain for the asynchronous line input.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q[0] <= line_in;
                    for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
                end
            end
            assign line_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // Purpose: previous line level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_s;
    end

    assign edge_s  = line_s & ~line_q;
    assign div_lim = sel_50hz ? CW'(DIV_50 - 1) : CW'(DIV_60 - 1);

    // Purpose: count pulses per tenth and tenths per second, cleared on realign.
    always_ff @(posedge clk) begin
        if (!rst_n || realign) begin
            cyc_q  <= '0;
            tenths <= '0;
        end else if (run && edge_s) begin
            if (cyc_q == div_lim) begin
                cyc_q  <= '0;
                tenths <= (tenths == TW'(TENTHS - 1)) ? '0 : tenths + TW'(1);
            end else begin
                cyc_q <= cyc_q + CW'(1);
            end
        end
    end

    assign sec_tick = run && edge_s && (cyc_q == div_lim) && (tenths == TW'(TENTHS - 1));

endmodule

// File: rtl/mcal_start_ctl.sv
// Write gating, power-fail flag and start-after-write control.
// A write is accepted only while wr_allow is high; counting starts at the
// stop event that closes a transaction containing an accepted write.
module mcal_start_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_allow,
    input  logic wr_done,
    output logic wr_acc,
    output logic realign,
    output logic running,
    output logic pwr_fail
);

    logic pending_q;

    assign wr_acc  = wr_en & wr_allow;
    assign realign = wr_acc | (wr_done & pending_q);

    // Purpose: track an open accepted transaction, start flag and power-fail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            running   <= 1'b0;
            pwr_fail  <= 1'b1;
        end else begin
            if (wr_acc) pwr_fail <= 1'b0;
            if (wr_done && (pending_q || wr_acc)) running <= 1'b1;
            pending_q <= wr_done ? 1'b0 : (pending_q | wr_acc);
        end
    end

endmodule

// File: rtl/mcal_time_chain.sv
// BCD carry chain from seconds to year and day of week, plus the field
// write path. A write in a cycle takes precedence and suppresses that
// cycle's tick. Assumes written values are legal BCD for their field.
module mcal_time_chain
    import mcal_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic          wr_acc,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output mcal_time_t    cur
);

    mcal_time_t nxt;
    logic       c_min, c_hr, c_day, c_mon, c_yr;
    logic [4:0] h12;
    logic       pm;

    // Purpose: next time value after one second, with all carries.
    always_comb begin
        nxt   = cur;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;
        h12   = cur.hour[4:0];
        pm    = cur.hour[5];

        if (cur.sec == 7'h59) begin
            nxt.sec = 7'h00;
            c_min   = 1'b1;
        end else begin
            nxt.sec = 7'(bcd_inc8({1'b0, cur.sec}));
        end

        if (c_min) begin
            if (cur.min == 7'h59) begin
                nxt.min = 7'h00;
                c_hr    = 1'b1;
            end else begin
                nxt.min = 7'(bcd_inc8({1'b0, cur.min}));
            end
        end

        if (c_hr) begin
            if (cur.hour[7]) begin
                if (cur.hour[5:0] == 6'h23) begin
                    nxt.hour = 8'h80;
                    c_day    = 1'b1;
                end else begin
                    nxt.hour = {2'b10, 6'(bcd_inc8({2'b00, cur.hour[5:0]}))};
                end
            end else begin
                if (h12 == 5'h11) begin
                    nxt.hour = {2'b00, ~pm, 5'h12};
                    c_day    = pm;
                end else if (h12 == 5'h12) begin
                    nxt.hour = {2'b00, pm, 5'h01};
                end else begin
                    nxt.hour = {2'b00, pm, 5'(bcd_inc8({3'b000, h12}))};
                end
            end
        end

        if (c_day) begin
            nxt.dow = (cur.dow == 3'd6) ? 3'd0 : cur.dow + 3'd1;
            if (cur.date == month_len(cur.month, cur.year)) begin
                nxt.date = 6'h01;
                c_mon    = 1'b1;
            end else begin
                nxt.date = 6'(bcd_inc8({2'b00, cur.date}));
            end
        end

        if (c_mon) begin
            if (cur.month == 5'h12) begin
                nxt.month = 5'h01;
                c_yr      = 1'b1;
            end else begin
                nxt.month = 5'(bcd_inc8({3'b000, cur.month}));
            end
        end

        if (c_yr) begin
            nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc8(cur.year);
        end
    end

    // Purpose: hold the live fields; writes override the second tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur.sec   <= 7'h00;
            cur.min   <= 7'h00;
            cur.hour  <= 8'h12;
            cur.date  <= 6'h01;
            cur.month <= 5'h01;
            cur.year  <= 8'h00;
            cur.dow   <= 3'd0;
        end else if (wr_acc) begin
            case (wr_addr)
                A_SEC:   cur.sec   <= wr_data[6:0];
                A_MIN:   cur.min   <= wr_data[6:0];
                A_HOUR:  cur.hour  <= {wr_data[7], 1'b0, wr_data[5:0]};
                A_DATE:  cur.date  <= wr_data[5:0];
                A_MON:   cur.month <= wr_data[4:0];
                A_YEAR:  cur.year  <= wr_data;
                A_DOW:   cur.dow   <= wr_data[2:0];
                default: ;
            endcase
        end else if (sec_tick) begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/mcal_shadow.sv
// Snapshot register set: copies every live byte on snap_req and serves
// reads from the copy, so a multi-byte read sees one coherent instant.
module mcal_shadow #(
    parameter int NR = 8,
    localparam int RAW = $clog2(NR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 snap_req,
    input  logic [NR-1:0][7:0]   live,
    input  logic [RAW-1:0]       rd_addr,
    output logic [NR-1:0][7:0]   shadow,
    output logic [7:0]           rd_data
);

    // Purpose: capture all live fields together on a snapshot strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        shadow <= '0;
        else if (snap_req) shadow <= live;
    end

    assign rd_data = shadow[rd_addr];

endmodule

// File: rtl/mains_calendar.sv
// Top of the mains-clocked BCD calendar: prescaler, start control,
// carry chain and snapshot. Assumes a clock much faster than the line.
module mains_calendar
    import mcal_pkg::*;
#(
    parameter int DIV_60      = 6,
    parameter int DIV_50      = 5,
    parameter int TENTHS      = 10,
    parameter int SYNC_STAGES = 2,
    localparam int TW         = $clog2(TENTHS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_in,
    input  logic          sel_50hz,
    input  logic          wr_allow,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          wr_done,
    input  logic          snap_req,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          running,
    output logic          pwr_fail
);

    logic                 wr_acc;
    logic                 realign;
    logic                 sec_tick;
    logic [TW-1:0]        tenths;
    logic [7:0]           sub_byte;
    mcal_time_t           t_q;
    logic [NREG-1:0][7:0] live;
    logic [NREG-1:0][7:0] shadow_flat;

    mcal_start_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_allow (wr_allow),
        .wr_done  (wr_done),
        .wr_acc   (wr_acc),
        .realign  (realign),
        .running  (running),
        .pwr_fail (pwr_fail)
    );

    mcal_tick_gen #(
        .DIV_60      (DIV_60),
        .DIV_50      (DIV_50),
        .TENTHS      (TENTHS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .sel_50hz (sel_50hz),
        .run      (running),
        .realign  (realign),
        .sec_tick (sec_tick),
        .tenths   (tenths)
    );

    mcal_time_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .wr_acc   (wr_acc),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cur      (t_q)
    );

    assign sub_byte     = 8'(tenths);
    assign live[A_SEC]  = {1'b0, t_q.sec};
    assign live[A_MIN]  = {1'b0, t_q.min};
    assign live[A_HOUR] = t_q.hour;
    assign live[A_DATE] = {2'b00, t_q.date};
    assign live[A_MON]  = {3'b000, t_q.month};
    assign live[A_YEAR] = t_q.year;
    assign live[A_DOW]  = {5'b00000, t_q.dow};
    assign live[A_SUB]  = sub_byte;

    mcal_shadow #(.NR(NREG)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap_req (snap_req),
        .live     (live),
        .rd_addr  (rd_addr),
        .shadow   (shadow_flat),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/mcal_checker.sv
// Property checker for the mains calendar, attached by bind.
module mcal_checker
    import mcal_pkg::*;
#(
    parameter int TENTHS = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 wr_allow,
    input logic                 snap_req,
    input logic                 running,
    input logic                 pwr_fail,
    input mcal_time_t           cur,
    input logic [7:0]           sub,
    input logic [NREG-1:0][7:0] shadow_flat
);

    a_r2_hold_until_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(wr_en && wr_allow)) |=> $stable(cur));

    a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    a_r3_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_allow && !running) |=> $stable(cur) && $stable(pwr_fail));

    a_r4_pf_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_fail) |-> $past(wr_en && wr_allow));

    a_r4_pf_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_fail |=> !pwr_fail);

    a_r6_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
        sub <= 8'(TENTHS - 1));

    a_r6_sub_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_allow) |=> (sub == 8'h00));

    a_r7_sec_bcd: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.sec[3:0] <= 4'd9) && (cur.sec <= 7'h59) && (cur.min <= 7'h59));

    a_r10_date_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.date != 6'h00) && (cur.date <= 6'h31));

    a_r13_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
        cur.dow <= 3'd6);

    a_r14_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(shadow_flat));

endmodule

bind mains_calendar mcal_checker #(.TENTHS(TENTHS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_allow    (wr_allow),
    .snap_req    (snap_req),
    .running     (running),
    .pwr_fail    (pwr_fail),
    .cur         (t_q),
    .sub         (sub_byte),
    .shadow_flat (shadow_flat)
);

// File: tb/mains_calendar_tb.sv
module mains_calendar_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       sel_50hz = 1'b0;
    logic       wr_allow = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_done = 1'b0;
    logic       snap_req = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       running;
    logic       pwr_fail;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mains_calendar u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .sel_50hz(sel_50hz),
        .wr_allow(wr_allow), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_done(wr_done), .snap_req(snap_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .running(running), .pwr_fail(pwr_fail)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int days_of(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic stop_ev();
        @(negedge clk); wr_done = 1'b1;
        @(negedge clk); wr_done = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); line_in = 1'b1;
            @(negedge clk); line_in = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic snap();
        @(negedge clk); snap_req = 1'b1;
        @(negedge clk); snap_req = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic chk_field(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, $sformatf("addr%0d", a), d, exp);
    endtask

    task automatic set_clk(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s); stop_ev();
    endtask

    task automatic set_day(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y, input logic [7:0] w);
        wr(3'd3, d); wr(3'd4, mo); wr(3'd5, y); wr(3'd6, w);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_h;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        snap();
        chk_field("R1", 3'd0, 8'h00); chk_field("R1", 3'd1, 8'h00);
        chk_field("R1", 3'd2, 8'h12); chk_field("R1", 3'd3, 8'h01);
        chk_field("R1", 3'd4, 8'h01); chk_field("R1", 3'd5, 8'h00);
        chk_field("R1", 3'd6, 8'h00); chk_field("R1", 3'd7, 8'h00);
        chk("R1", "pwr_fail", {7'd0, pwr_fail}, 8'h01);
        chk("R1", "running", {7'd0, running}, 8'h00);

        // R2 no counting before the first write
        pulses(130); snap();
        chk_field("R2", 3'd0, 8'h00); chk_field("R2", 3'd7, 8'h00);
        chk("R2", "running", {7'd0, running}, 8'h00);

        // R3 writes blocked while wr_allow low
        wr(3'd0, 8'h30); stop_ev(); pulses(70); snap();
        chk_field("R3", 3'd0, 8'h00);
        chk("R3", "pwr_fail", {7'd0, pwr_fail}, 8'h01);
        chk("R3", "running", {7'd0, running}, 8'h00);

        // R4 first accepted write clears the flag; R2 stop starts counting
        wr_allow = 1'b1;
        wr(3'd0, 8'h10);
        chk("R4", "pwr_fail", {7'd0, pwr_fail}, 8'h00);
        chk("R2", "running before stop", {7'd0, running}, 8'h00);
        stop_ev();
        chk("R2", "running after stop", {7'd0, running}, 8'h01);

        // R5 60 Hz: six pulses per tenth
        pulses(18); snap(); chk_field("R5", 3'd7, 8'h03);
        pulses(5);  snap(); chk_field("R5", 3'd7, 8'h03);
        pulses(1);  snap(); chk_field("R5", 3'd7, 8'h04);
        // R6 write forces sub-second to 0, stop re-aligns the phase
        wr(3'd1, 8'h00); snap(); chk_field("R6", 3'd7, 8'h00);
        stop_ev();
        pulses(59); snap(); chk_field("R6", 3'd0, 8'h10); chk_field("R6", 3'd7, 8'h09);
        pulses(1);  snap(); chk_field("R6", 3'd0, 8'h11); chk_field("R6", 3'd7, 8'h00);
        // R6 address 7 is read-only
        wr(3'd7, 8'h55); stop_ev(); snap();
        chk_field("R6", 3'd7, 8'h00); chk_field("R6", 3'd0, 8'h11);

        // R5 50 Hz: five pulses per tenth
        sel_50hz = 1'b1;
        set_clk(8'h81, 8'h00, 8'h00);
        pulses(50); snap(); chk_field("R5", 3'd0, 8'h01); chk_field("R5", 3'd7, 8'h00);
        pulses(5);  snap(); chk_field("R5", 3'd7, 8'h01);
        pulses(4);  snap(); chk_field("R5", 3'd7, 8'h01);
        sel_50hz = 1'b0;

        // R7 full minute sweep, second by second
        set_clk(8'h85, 8'h07, 8'h00);
        for (int s = 1; s <= 60; s++) begin
            pulses(60); snap();
            chk_field("R7", 3'd0, to_bcd(s % 60));
        end
        chk_field("R7", 3'd1, 8'h08);
        set_clk(8'h85, 8'h59, 8'h59);
        pulses(60); snap();
        chk_field("R7", 3'd1, 8'h00); chk_field("R7", 3'd2, 8'h86);

        // R8 24-hour sweep
        set_day(8'h10, 8'h05, 8'h01, 8'h02);
        for (int k = 0; k < 24; k++) begin
            set_clk(8'h80 | to_bcd(k), 8'h59, 8'h59);
            pulses(60); snap();
            chk_field("R8", 3'd2, 8'h80 | to_bcd((k + 1) % 24));
        end
        chk_field("R8", 3'd3, 8'h11); chk_field("R13", 3'd6, 8'h03);

        // R9 12-hour sweep
        set_day(8'h10, 8'h05, 8'h01, 8'h02);
        for (int k = 0; k < 24; k++) begin
            int n;
            n = (k + 1) % 24;
            exp_h = to_bcd(((k % 12) == 0) ? 12 : (k % 12)) | ((k >= 12) ? 8'h20 : 8'h00);
            set_clk(exp_h, 8'h59, 8'h59);
            pulses(60); snap();
            exp_h = to_bcd(((n % 12) == 0) ? 12 : (n % 12)) | ((n >= 12) ? 8'h20 : 8'h00);
            chk_field("R9", 3'd2, exp_h);
        end
        chk_field("R9", 3'd3, 8'h11);

        // R10 R12 R13 last day of every month in year 01
        for (int m = 1; m <= 12; m++) begin
            set_day(to_bcd(days_of(m, 1)), to_bcd(m), 8'h01, 8'h06);
            set_clk(8'h23 | 8'h80, 8'h59, 8'h59);
            pulses(60); snap();
            chk_field("R10", 3'd3, 8'h01);
            chk_field("R12", 3'd4, to_bcd(m == 12 ? 1 : m + 1));
            chk_field("R12", 3'd5, (m == 12) ? 8'h02 : 8'h01);
            chk_field("R13", 3'd6, 8'h00);
        end

        // R11 February 28 in every two-digit year
        for (int y = 0; y < 100; y++) begin
            set_day(8'h28, 8'h02, to_bcd(y), 8'h01);
            set_clk(8'hA3, 8'h59, 8'h59);
            pulses(60); snap();
            chk_field("R11", 3'd3, (y % 4 == 0) ? 8'h29 : 8'h01);
            chk_field("R11", 3'd4, (y % 4 == 0) ? 8'h02 : 8'h03);
        end

        // R12 year 99 wraps to 00
        set_day(8'h31, 8'h12, 8'h99, 8'h04);
        set_clk(8'h11 | 8'h20, 8'h59, 8'h59);
        pulses(60); snap();
        chk_field("R12", 3'd5, 8'h00); chk_field("R12", 3'd4, 8'h01);
        chk_field("R9", 3'd2, 8'h12);

        // R14 shadow holds until the next snapshot
        set_clk(8'h80, 8'h00, 8'h20);
        snap();
        pulses(60);
        chk_field("R14", 3'd0, 8'h20);
        snap();
        chk_field("R14", 3'd0, 8'h21);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule